// File: doc/BRIEF.md
# Interleaved Image Byte Selector

This block sits between a byte stream that carries several images woven together and a consumer that wants only one of them. The combined stream is cut into fixed-size chunks. The chunks are dealt out round-robin: the first chunk belongs to image 1, the next to image 2, and so on up to the image count, after which the cycle repeats. A restart pulse captures a 1-based image select and the image count, and clears the byte position. From then on every byte of a chunk owned by the selected image goes to the output. Every other byte is accepted upstream and discarded, so the source never stalls on data nobody wants.

The position is kept by two counters instead of a divider. One counts the offset within the current chunk and the other holds the owner index of that chunk, wrapping at the captured count. A three-state machine (HALT, PASS, DROP) decides per chunk whether bytes pass through or are drained. In PASS the handshake is combinational and carries no extra latency: `dn_valid` follows `up_valid` and `up_ready` follows `dn_ready`. In DROP, `up_ready` is held high and `dn_valid` is held low.

State transitions:
- HALT→PASS/DROP: taken on restart. PASS is chosen when the select is 1 and is valid for the count.
- PASS/DROP→PASS/DROP: taken at the accepted last byte of a chunk. PASS is chosen when the next chunk's owner equals select−1.
- Any state→PASS/DROP: taken on restart, using the same rule as from HALT.

Top module: `image_lane_picker`

## Requirements
- R1: After reset and before the first restart, `up_ready` and `dn_valid` are both 0 and no byte is accepted.
- R2: In the cycle `restart` is 1, `up_ready` and `dn_valid` are 0, so a byte offered in that cycle is not consumed. At that clock edge `img_sel` and `img_count` are captured and the byte position returns to zero.
- R3: Each accepted byte has an owner index equal to (bytes accepted since restart / CHUNK_LEN) mod captured count. CHUNK_LEN defaults to 288.
- R4: A byte whose owner index equals captured select − 1 appears on `dn_data` unchanged, with `dn_valid` 1. Forwarded bytes keep their order.
- R5: A byte whose owner differs is accepted with `up_ready` 1 while `dn_valid` stays 0.
- R6: The position advances on every accepted byte, whether it is forwarded or drained.
- R7: While forwarding with `dn_ready` 0, `up_ready` is 0 and the byte stays offered.
- R8: Changes on `img_sel` or `img_count` between restarts have no effect on which bytes are forwarded.
- R9: A captured select of 0, or one greater than the captured count, drains every byte.
- R10: With a captured count of 1 and a select of 1, every byte is forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| restart | input | 1 | Capture select/count, clear position |
| img_sel | input | SEL_W | 1-based image select |
| img_count | input | SEL_W | Number of interleaved images |
| up_valid | input | 1 | Upstream byte valid |
| up_data | input | DATA_W | Upstream byte |
| up_ready | output | 1 | Upstream byte accepted |
| dn_valid | output | 1 | Filtered byte valid |
| dn_data | output | DATA_W | Filtered byte |
| dn_ready | input | 1 | Consumer ready |

## Verification
A restart and an upstream byte can arrive in the same cycle. The bench raises `restart` with `up_valid` high partway through a chunk. It checks that the offered byte is refused and not forwarded in that cycle. It then re-offers the byte and expects it to count as position zero under the newly captured select. Consumer backpressure is also made to coincide with chunk boundaries in a forwarding phase. The scoreboard must still see every owned byte exactly once, in order.

// File: rtl/lane_pick_pkg.sv
package lane_pick_pkg;
    typedef enum logic [1:0] {
        ST_HALT = 2'd0,
        ST_PASS = 2'd1,
        ST_DROP = 2'd2
    } pick_state_e;
endpackage

// File: rtl/lane_select_hold.sv
module lane_select_hold #(
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [SEL_W-1:0] img_sel,
    input  logic [SEL_W-1:0] img_count,
    output logic [SEL_W-1:0] tgt_q,
    output logic [SEL_W-1:0] cnt_q,
    output logic             sel_ok_q,
    output logic             arm_hit
);
    logic sel_ok_raw;

    always_comb begin
        sel_ok_raw = (img_sel != '0) && (img_sel <= img_count);
        arm_hit    = sel_ok_raw && (img_sel == SEL_W'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt_q    <= '0;
            cnt_q    <= '0;
            sel_ok_q <= 1'b0;
        end else if (restart) begin
            tgt_q    <= img_sel - SEL_W'(1);
            cnt_q    <= img_count;
            sel_ok_q <= sel_ok_raw;
        end
    end

    // captured configuration only moves at a restart
    assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |=> ($stable(tgt_q) && $stable(cnt_q) && $stable(sel_ok_q)));
endmodule

// File: rtl/lane_chunk_tracker.sv
module lane_chunk_tracker #(
    parameter int CHUNK_LEN = 288,
    parameter int SEL_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic [SEL_W-1:0] cnt_q,
    output logic             chunk_end,
    output logic [SEL_W-1:0] idx_nxt
);
    localparam int              OFF_W    = (CHUNK_LEN > 1) ? $clog2(CHUNK_LEN) : 1;
    localparam logic [OFF_W-1:0] OFF_LAST = OFF_W'(CHUNK_LEN - 1);

    logic [OFF_W-1:0] off_q;
    logic [SEL_W-1:0] idx_q;
    logic [SEL_W:0]   idx_inc;

    always_comb begin
        idx_inc   = {1'b0, idx_q} + (SEL_W + 1)'(1);
        idx_nxt   = (idx_inc >= {1'b0, cnt_q}) ? '0 : idx_inc[SEL_W-1:0];
        chunk_end = step && (off_q == OFF_LAST);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_q <= '0;
            idx_q <= '0;
        end else if (clear) begin
            off_q <= '0;
            idx_q <= '0;
        end else if (step) begin
            if (off_q == OFF_LAST) begin
                off_q <= '0;
                idx_q <= idx_nxt;
            end else begin
                off_q <= off_q + OFF_W'(1);
            end
        end
    end

    assert_off_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        off_q <= OFF_LAST);
    assert_idx_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |-> (idx_q < cnt_q));
    assert_clear_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (off_q == '0 && idx_q == '0));
    assert_step_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear && off_q != OFF_LAST) |=> (off_q == $past(off_q) + OFF_W'(1)));
endmodule

// File: rtl/image_lane_picker.sv
module image_lane_picker
    import lane_pick_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int CHUNK_LEN  = 288,
    parameter int MAX_IMAGES = 8,
    localparam int SEL_W     = $clog2(MAX_IMAGES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic [SEL_W-1:0]  img_sel,
    input  logic [SEL_W-1:0]  img_count,
    input  logic              up_valid,
    input  logic [DATA_W-1:0] up_data,
    output logic              up_ready,
    output logic              dn_valid,
    output logic [DATA_W-1:0] dn_data,
    input  logic              dn_ready
);
    pick_state_e      state_q, state_d;
    logic [SEL_W-1:0] tgt_q, cnt_q, idx_nxt;
    logic             sel_ok_q, arm_hit, chunk_end, step;

    lane_select_hold #(.SEL_W(SEL_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .img_sel(img_sel), .img_count(img_count),
        .tgt_q(tgt_q), .cnt_q(cnt_q), .sel_ok_q(sel_ok_q), .arm_hit(arm_hit)
    );

    lane_chunk_tracker #(.CHUNK_LEN(CHUNK_LEN), .SEL_W(SEL_W)) u_track (
        .clk(clk), .rst_n(rst_n), .clear(restart), .step(step),
        .cnt_q(cnt_q), .chunk_end(chunk_end), .idx_nxt(idx_nxt)
    );

    assign step = up_valid && up_ready;

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (restart) begin
            state_d = arm_hit ? ST_PASS : ST_DROP;
        end else begin
            unique case (state_q)
                ST_HALT: state_d = ST_HALT;
                ST_PASS, ST_DROP: begin
                    if (chunk_end)
                        state_d = (sel_ok_q && idx_nxt == tgt_q) ? ST_PASS : ST_DROP;
                end
                default: state_d = ST_HALT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    // output logic
    always_comb begin
        dn_data  = up_data;
        up_ready = 1'b0;
        dn_valid = 1'b0;
        if (!restart) begin
            unique case (state_q)
                ST_HALT: begin
                    up_ready = 1'b0;
                    dn_valid = 1'b0;
                end
                ST_PASS: begin
                    up_ready = dn_ready;
                    dn_valid = up_valid;
                end
                ST_DROP: begin
                    up_ready = 1'b1;
                    dn_valid = 1'b0;
                end
                default: begin
                    up_ready = 1'b0;
                    dn_valid = 1'b0;
                end
            endcase
        end
    end

    assert_halt_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT && !restart) |-> (!up_ready && !dn_valid));
    assert_restart_block_R2: assert property (@(posedge clk) disable iff (!rst_n)
        restart |-> (!up_ready && !dn_valid));
    assert_out_needs_in_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid |-> up_valid);
    assert_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && !dn_ready) |-> !up_ready);
    assert_bad_sel_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_ok_q && state_q != ST_HALT) |-> !dn_valid);
endmodule

// File: tb/sim_image_lane_picker.sv
module sim_image_lane_picker;
    localparam int DW = 8;
    localparam int CL = 288;
    localparam int SW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          restart = 1'b0;
    logic [SW-1:0] img_sel = '0;
    logic [SW-1:0] img_count = '0;
    logic          up_valid = 1'b0;
    logic [DW-1:0] up_data = '0;
    logic          up_ready;
    logic          dn_valid;
    logic [DW-1:0] dn_data;
    logic          dn_ready = 1'b1;

    int checks = 0;
    int fails  = 0;
    string ph_req = "R4";
    logic [DW-1:0] expq[$];
    bit bp_mode = 1'b0;
    logic [7:0] lfsr = 8'h5B;
    int m_sel = 0, m_cnt = 0, m_sent = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    image_lane_picker #(.DATA_W(DW), .CHUNK_LEN(CL), .MAX_IMAGES(8)) u0 (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .img_sel(img_sel), .img_count(img_count),
        .up_valid(up_valid), .up_data(up_data), .up_ready(up_ready),
        .dn_valid(dn_valid), .dn_data(dn_data), .dn_ready(dn_ready)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit owned(input int pos);
        if (m_sel < 1 || m_sel > m_cnt || m_cnt == 0) return 1'b0;
        return ((pos / CL) % m_cnt) == (m_sel - 1);
    endfunction

    // monitor: drives consumer ready, pops the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            dn_ready = bp_mode ? lfsr[0] : 1'b1;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            #2;
            if (dn_valid && !dn_ready)
                check(!up_ready, "R7", up_ready, 0);
            if (dn_valid && dn_ready) begin
                if (expq.size() == 0) begin
                    check(1'b0, ph_req, dn_data, -1);
                end else begin
                    logic [DW-1:0] e;
                    e = expq.pop_front();
                    check(dn_data == e, ph_req, dn_data, e);
                end
            end
        end
    end

    task automatic do_restart(input int s, input int c, input bit offer);
        @(negedge clk);
        restart = 1'b1;
        img_sel = SW'(s);
        img_count = SW'(c);
        up_valid = offer;
        up_data = 8'hA5;
        #1;
        check(!up_ready && !dn_valid, "R2", {up_ready, dn_valid}, 0);
        @(negedge clk);
        restart = 1'b0;
        up_valid = 1'b0;
        m_sel = s;
        m_cnt = c;
        m_sent = 0;
    endtask

    task automatic send(input int n, input int seed, input string drain_req);
        for (int i = 0; i < n; i++) begin
            bit f;
            @(negedge clk);
            up_valid = 1'b1;
            up_data = DW'(i * 7 + seed);
            f = owned(m_sent);
            #1;
            if (f) expq.push_back(up_data);
            else   check(!dn_valid && up_ready, drain_req, {dn_valid, up_ready}, 1);
            while (!up_ready) begin
                @(negedge clk);
                #1;
            end
            @(posedge clk);
            m_sent++;
        end
        @(negedge clk);
        up_valid = 1'b0;
    endtask

    task automatic phase_end(input string req);
        repeat (3) @(negedge clk);
        check(expq.size() == 0, req, expq.size(), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: quiet before first restart, even with a byte offered
        @(negedge clk);
        up_valid = 1'b1;
        up_data = 8'h3C;
        #1;
        check(!up_ready, "R1", up_ready, 0);
        check(!dn_valid, "R1", dn_valid, 0);
        @(negedge clk);
        up_valid = 1'b0;

        // R3/R4/R6: three images, select 2
        ph_req = "R4";
        do_restart(2, 3, 1'b0);
        send(1000, 3, "R5");
        phase_end("R6");

        // R7/R8: four images, select 4, backpressure, inputs changed mid-run
        ph_req = "R3";
        bp_mode = 1'b1;
        do_restart(4, 4, 1'b0);
        send(700, 11, "R5");
        img_sel = SW'(1);
        img_count = SW'(2);
        ph_req = "R8";
        send(800, 40, "R8");
        phase_end("R8");
        bp_mode = 1'b0;

        // R9: invalid selects
        ph_req = "R9";
        do_restart(0, 3, 1'b0);
        send(400, 5, "R9");
        do_restart(5, 4, 1'b0);
        send(300, 9, "R9");
        phase_end("R9");

        // R10: single image
        ph_req = "R10";
        bp_mode = 1'b1;
        do_restart(1, 1, 1'b0);
        send(400, 17, "R10");
        phase_end("R10");
        bp_mode = 1'b0;

        // R2: restart mid-chunk with a byte offered in the same cycle
        ph_req = "R2";
        do_restart(2, 2, 1'b0);
        send(100, 21, "R5");
        do_restart(1, 2, 1'b1);
        send(700, 2, "R5");
        phase_end("R2");

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule